// File: doc/BRIEF.md
# Coordinated timing-packet departure multiplexer

This block puts two sources onto one byte-wide egress link, one byte per clock. The first source is a buffered stream of background frames. The second is a locally built timing frame, which is released on a request pulse from a rate scheduler. Background bytes enter a local FIFO and leave as whole frames while no timing frame is waiting. When a timing request arrives, a frame already in progress is finished. No new background frame starts after that. The link then stays idle for a computed safe window, and only then is the timing frame sent. Because of this window, the timing frame never queues behind background traffic at any downstream store-and-forward hop, up to a configured hop count.

The safe window is recomputed at the end of every background frame. It is derived from three inputs: the frame's byte length, the timing-frame length and the hop count. A reservation left over from earlier frames is carried forward into the new value. The timing frame's bytes are fetched by index from an external template source. While the FIFO holds too much data, a backpressure request with hysteresis goes to the upstream source, so no background byte is ever lost.

Top module: `sync_gap_mux`

## Requirements
- R1: During and straight after reset, the egress is idle (`out_valid`=0), `pause_req`=0, `in_ready`=1 and `sync_idx`=0.
- R2: Background bytes leave in arrival order with unchanged data. `out_last`=1 marks exactly the byte that entered with `in_last`=1, and `out_sync`=0 on every background byte.
- R3: A byte is accepted only when `in_ready`=1. `in_ready` is 0 while the FIFO holds FIFO_DEPTH bytes. Every accepted byte is later emitted; none is dropped.
- R4: Once a background frame has started, its bytes continue to its last byte before any timing byte appears. A timing frame never interrupts a background frame.
- R5: Between any two frames at least IFG_CYC idle cycles pass. With background data waiting and no timing request pending, the next frame starts after exactly IFG_CYC idle cycles, whether the previous frame was background or timing.
- R6: A background frame of L bytes may end while a timing request is pending and no earlier reservation is outstanding. The idle time before the timing frame is then IFG_CYC if L <= SYNC_LEN, and (HOPS-1)*(L-SYNC_LEN)+IFG_CYC if L > SYNC_LEN.
- R7: A background frame may start while r idle cycles of an earlier reservation remain, with r > 0. The idle time after it is then the largest of r+IFG_CYC, the R6 value for its own length, and IFG_CYC.
- R8: A timing frame is SYNC_LEN consecutive bytes with `out_sync`=1. Byte k carries the `sync_byte` value presented while `sync_idx`=k, for k = 0..SYNC_LEN-1. `out_last`=1 is set only on byte SYNC_LEN-1.
- R9: `pause_req` rises when FIFO occupancy is at least HI_MARK and falls only once occupancy is at most LO_MARK. Between the two marks it keeps its previous value.
- R10: A pending timing request blocks the start of a background frame. If both could start in the same cycle, the timing frame goes first.
- R11: Further request pulses that arrive while a request is already pending produce no extra timing frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Background byte valid |
| in_ready | output | 1 | FIFO can accept a byte |
| in_data | input | DATA_W | Background byte |
| in_last | input | 1 | Final byte of a background frame |
| sync_req | input | 1 | One-cycle timing-frame request from the rate scheduler |
| sync_idx | output | $clog2(SYNC_LEN) | Index of the timing byte being fetched |
| sync_byte | input | DATA_W | Template byte for `sync_idx`, combinational |
| out_valid | output | 1 | Egress byte valid |
| out_data | output | DATA_W | Egress byte |
| out_last | output | 1 | Final byte of the egress frame |
| out_sync | output | 1 | Egress byte belongs to a timing frame |
| pause_req | output | 1 | Backpressure request toward the background source |

## Verification
Two decisions can fall in the same cycle: a background frame becoming eligible to start, because its first byte has just reached the FIFO, and a timing request becoming pending. The bench provokes this by pulsing `sync_req` on the same edge that writes the frame's first byte. It judges the outcome by the timing frame appearing first on the egress, followed by the background frame after exactly the inter-frame gap. A second pairing is a new request pulse landing while an earlier request is still waiting out its safe window. This is judged by counting a single timing frame with the expected gap.

// File: rtl/sync_gap_mux.sv
module sync_gap_mux #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int HI_MARK    = 12,
  parameter int LO_MARK    = 4,
  parameter int IFG_CYC    = 12,
  parameter int SYNC_LEN   = 64,
  parameter int HOPS       = 16,
  parameter int LEN_W      = 11,
  parameter int GAP_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [DATA_W-1:0]           in_data,
  input  logic                        in_last,
  input  logic                        sync_req,
  output logic [$clog2(SYNC_LEN)-1:0] sync_idx,
  input  logic [DATA_W-1:0]           sync_byte,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           out_data,
  output logic                        out_last,
  output logic                        out_sync,
  output logic                        pause_req
);
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int CW    = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W = $clog2(SYNC_LEN);
  localparam logic [CW-1:0]    FULL_C = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0]    HI_C   = CW'(HI_MARK);
  localparam logic [CW-1:0]    LO_C   = CW'(LO_MARK);
  localparam logic [GAP_W-1:0] IFG_G  = GAP_W'(IFG_CYC);
  localparam logic [GAP_W-1:0] GAP_MX = '1;
  localparam logic [31:0] S32    = 32'(SYNC_LEN);
  localparam logic [31:0] H1_32  = 32'(HOPS - 1);
  localparam logic [31:0] IFG32  = 32'(IFG_CYC);
  localparam logic [31:0] GMAX32 = 32'(GAP_MX);

  typedef enum logic [1:0] {ST_IDLE, ST_BG, ST_SYNC} st_t;

  logic [DATA_W:0] mem [FIFO_DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic [DATA_W:0] head;

  st_t              st;
  logic             armed;
  logic [GAP_W-1:0] idle_cnt, gap_need, r0, r_now;
  logic [LEN_W-1:0] bg_len;
  logic [IDX_W-1:0] sidx;

  logic wr, empty, bg_start, sync_start, bg_fire, bg_end, sync_fire, sync_end;
  logic [31:0] len32, r_use, t1, t2, g32;

  assign in_ready   = (cnt != FULL_C);
  assign wr         = in_valid & in_ready;
  assign empty      = (cnt == '0);
  assign head       = mem[rp];
  assign sync_idx   = sidx;
  assign r_now      = (gap_need > idle_cnt) ? gap_need - idle_cnt : '0;

  assign bg_start   = (st == ST_IDLE) & ~armed & ~empty & (idle_cnt >= IFG_G);
  assign sync_start = (st == ST_IDLE) & armed & (idle_cnt >= gap_need);
  assign bg_fire    = bg_start | ((st == ST_BG) & ~empty);
  assign bg_end     = bg_fire & head[DATA_W];
  assign sync_fire  = sync_start | (st == ST_SYNC);
  assign sync_end   = sync_fire & (sidx == IDX_W'(SYNC_LEN - 1));

  always_comb begin
    len32 = bg_start ? 32'd1 : 32'(bg_len) + 32'd1;
    r_use = bg_start ? 32'(r_now) : 32'(r0);
    t1    = (r_use != 32'd0) ? r_use + IFG32 : 32'd0;
    t2    = (len32 > S32) ? H1_32 * (len32 - S32) + IFG32 : 32'd0;
    g32   = IFG32;
    if (t1 > g32) g32 = t1;
    if (t2 > g32) g32 = t2;
    if (g32 > GMAX32) g32 = GMAX32;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= {in_last, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      pause_req <= 1'b0;
    end else begin
      if (wr) wp <= (wp == AW'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (bg_fire) rp <= (rp == AW'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(bg_fire);
      if (cnt >= HI_C) pause_req <= 1'b1;
      else if (cnt <= LO_C) pause_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      armed <= 1'b0;
      idle_cnt <= GAP_MX;
      gap_need <= '0;
      r0 <= '0;
      bg_len <= '0;
      sidx <= '0;
    end else begin
      armed <= (armed & ~sync_start) | sync_req;
      if (bg_end | sync_end) idle_cnt <= '0;
      else if (~bg_fire & ~sync_fire & (idle_cnt != GAP_MX)) idle_cnt <= idle_cnt + 1'b1;
      if (bg_end) gap_need <= GAP_W'(g32);
      else if (sync_end) gap_need <= IFG_G;
      if (bg_start) r0 <= r_now;
      if (bg_start) bg_len <= LEN_W'(1);
      else if (bg_fire) bg_len <= bg_len + 1'b1;
      if (sync_fire) sidx <= sync_end ? '0 : sidx + 1'b1;
      case (st)
        ST_IDLE: if (sync_start) st <= ST_SYNC;
                 else if (bg_start & ~head[DATA_W]) st <= ST_BG;
        ST_BG:   if (bg_end) st <= ST_IDLE;
        ST_SYNC: if (sync_end) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_sync  <= 1'b0;
    end else begin
      out_valid <= bg_fire | sync_fire;
      out_data  <= sync_fire ? sync_byte : head[DATA_W-1:0];
      out_last  <= bg_end | sync_end;
      out_sync  <= sync_fire;
    end
  end
endmodule

// File: rtl/sync_gap_mux_chk.sv
module sync_gap_mux_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int HI_MARK    = 12,
  parameter int LO_MARK    = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              in_ready,
  input logic                              out_valid,
  input logic                              out_last,
  input logic                              out_sync,
  input logic                              pause_req,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]   cnt
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0] HI_C   = CW'(HI_MARK);
  localparam logic [CW-1:0] LO_C   = CW'(LO_MARK);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL_C) |=> (cnt <= FULL_C));
  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (cnt == FULL_C));
  p_no_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sync && !out_last) |=> !out_sync);
  p_ifg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);
  p_sync_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sync && !out_last) |=> (out_valid && out_sync));
  p_pause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> ($past(cnt) >= HI_C));
  p_pause_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_req) |-> ($past(cnt) <= LO_C));
endmodule

bind sync_gap_mux sync_gap_mux_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_last(out_last), .out_sync(out_sync), .pause_req(pause_req), .cnt(cnt)
);

// File: tb/sync_gap_mux_tb.sv
`timescale 1ns/1ps
module sync_gap_mux_tb;
  localparam int SL  = 8;
  localparam int IFG = 4;
  localparam int NV  = 5;
  // {frame length, sync pulse index (>= length: after frame), expected idle gap, first byte}
  localparam int VEC [NV][4] = '{
    '{4, 1, 4, 8'h10}, '{8, 3, 4, 8'h20}, '{10, 2, 8, 8'h30},
    '{20, 5, 28, 8'h50}, '{1, 1, 4, 8'h70}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_last, sync_req;
  logic out_valid, out_last, out_sync, pause_req;
  logic [7:0] in_data, out_data, sync_byte;
  logic [2:0] sync_idx;

  assign sync_byte = 8'hC0 + 8'(sync_idx);

  sync_gap_mux #(.DATA_W(8), .FIFO_DEPTH(16), .HI_MARK(12), .LO_MARK(4),
    .IFG_CYC(IFG), .SYNC_LEN(SL), .HOPS(3), .LEN_W(11), .GAP_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .sync_req(sync_req),
    .sync_idx(sync_idx), .sync_byte(sync_byte), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_sync(out_sync),
    .pause_req(pause_req));

  int n_cmp = 0, n_bad = 0, cyc = 0, mon_n = 0;
  int r_cyc [1024];
  logic [7:0] r_dat [1024];
  logic r_last [1024], r_sync [1024];
  logic saw_full = 1'b0;
  int full_nopause = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (out_valid && mon_n < 1024) begin
      r_cyc[mon_n] = cyc; r_dat[mon_n] = out_data;
      r_last[mon_n] = out_last; r_sync[mon_n] = out_sync;
      mon_n++;
    end
    if (rst_n && !in_ready) begin
      saw_full = 1'b1;
      if (!pause_req) full_nopause++;
    end
  end

  task automatic expect_eq(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_sync();
    sync_req = 1'b1; @(posedge clk); #1; sync_req = 1'b0;
  endtask

  task automatic send_frame(int len, int first, int s1, int s2);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = 8'(first + i); in_last = (i == len - 1);
      while (!in_ready) begin @(posedge clk); #1; end
      sync_req = (i == s1) || (i == s2);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0; sync_req = 1'b0;
    if (s1 >= len) pulse_sync();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  function automatic int find_sync(int base);
    for (int i = base; i < mon_n; i++) if (r_sync[i]) return i;
    return -1;
  endfunction

  function automatic int count_bg(int base);
    int c = 0;
    for (int i = base; i < mon_n; i++) if (!r_sync[i]) c++;
    return c;
  endfunction

  function automatic int nth_bg(int base, int n);
    int c = 0;
    for (int i = base; i < mon_n; i++) if (!r_sync[i]) begin
      if (c == n) return i;
      c++;
    end
    return -1;
  endfunction

  function automatic int count_sync_frames(int base);
    int c = 0;
    for (int i = base; i < mon_n; i++)
      if (r_sync[i] && (i == base || !r_sync[i-1] || r_last[i-1])) c++;
    return c;
  endfunction

  task automatic check_bg(string tag, int base, int skip, int len, int first);
    int ok = 1;
    for (int k = 0; k < len; k++) begin
      int ix = nth_bg(base, skip + k);
      if (ix < 0 || r_dat[ix] != 8'(first + k) || r_last[ix] != (k == len - 1)) ok = 0;
    end
    expect_eq(tag, ok, 1);
  endtask

  task automatic check_sync(string tag, int j);
    int ok = (j >= 0);
    for (int k = 0; k < SL && ok != 0; k++) begin
      if (!r_sync[j+k] || r_dat[j+k] != 8'hC0 + 8'(k) || r_last[j+k] != (k == SL - 1)
          || r_cyc[j+k] - r_cyc[j] != k) ok = 0;
    end
    expect_eq(tag, ok, 1);
  endtask

  task automatic wait_bg(int base, int n);
    while (count_bg(base) < n) begin @(negedge clk); #1; end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base, j;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; sync_req = 1'b0;
    idle(4);
    @(negedge clk);
    expect_eq("R1 out_valid in reset", out_valid, 0);
    expect_eq("R1 pause in reset", pause_req, 0);
    expect_eq("R1 in_ready in reset", in_ready, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R1 out_valid after reset", out_valid, 0);
    expect_eq("R1 sync_idx after reset", sync_idx, 0);
    idle(5);

    // Table walk: single frame, SYNC requested during/after it (R6, R2, R4, R8)
    for (int v = 0; v < NV; v++) begin
      base = mon_n;
      send_frame(VEC[v][0], VEC[v][3], VEC[v][1], -1);
      idle(70);
      j = find_sync(base);
      expect_eq($sformatf("R4 bg precedes sync v%0d", v), j - base, VEC[v][0]);
      if (j > base) begin
        expect_eq($sformatf("R4 bg last before sync v%0d", v), r_last[j-1], 1);
        expect_eq($sformatf("R6 gap v%0d", v), r_cyc[j] - r_cyc[j-1] - 1, VEC[v][2]);
      end
      check_bg($sformatf("R2 bg data v%0d", v), base, 0, VEC[v][0], VEC[v][3]);
      check_sync($sformatf("R8 sync frame v%0d", v), j);
    end

    // R7 carried reservation and R5 back-to-back background frames
    base = mon_n;
    send_frame(20, 8'h10, -1, -1);
    send_frame(9, 8'h40, -1, -1);
    pulse_sync();
    idle(80);
    j = nth_bg(base, 19);
    expect_eq("R5 idle between bg frames", r_cyc[j+1] - r_cyc[j] - 1, IFG);
    j = find_sync(base);
    expect_eq("R7 carried gap", r_cyc[j] - r_cyc[j-1] - 1, 28);
    check_bg("R2 frame A", base, 0, 20, 8'h10);
    check_bg("R2 frame B", base, 20, 9, 8'h40);

    // R10 sync request lands with a frame becoming eligible
    base = mon_n;
    send_frame(5, 8'h80, 0, -1);
    idle(40);
    expect_eq("R10 sync goes first", r_sync[base], 1);
    check_sync("R8 sync when link idle", base);
    expect_eq("R5 bg after sync idle", r_cyc[base+SL] - r_cyc[base+SL-1] - 1, IFG);
    check_bg("R2 blocked frame", base, 0, 5, 8'h80);

    // R11 repeated request while pending
    base = mon_n;
    send_frame(10, 8'h90, 2, 5);
    idle(60);
    expect_eq("R11 single sync frame", count_sync_frames(base), 1);
    j = find_sync(base);
    expect_eq("R11 gap unchanged", r_cyc[j] - r_cyc[j-1] - 1, 8);

    // R3 and R9: backlog builds during the gap
    base = mon_n;
    send_frame(20, 8'h10, 1, -1);
    send_frame(20, 8'h60, -1, -1);
    expect_eq("R3 fifo reached full", saw_full, 1);
    expect_eq("R9 pause high while full", full_nopause, 0);
    wait_bg(base, 32);
    expect_eq("R9 pause held between marks", pause_req, 1);
    wait_bg(base, 39);
    @(negedge clk); #1;
    expect_eq("R9 pause released", pause_req, 0);
    idle(20);
    j = find_sync(base);
    expect_eq("R6 gap before backlog", r_cyc[j] - r_cyc[j-1] - 1, 28);
    expect_eq("R5 backlog after sync", r_cyc[j+SL] - r_cyc[j+SL-1] - 1, IFG);
    check_bg("R3 no byte lost", base, 20, 20, 8'h60);
    expect_eq("R3 in_ready after drain", in_ready, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule